// File: doc/BRIEF.md
# Oscillator Startup Fault Counter

This block watches oscillators while they start. Each monitored oscillator has its own counter. The counter advances by one for every oscillator cycle tick that arrives while the oscillator reports that it is running. When a programmed number of ticks has been seen, the block raises a one-cycle expiry pulse for that oscillator toward the interrupt controller. A level output stays high after that, showing that the start-up window has elapsed.

There are three instances. Instance 0 monitors the low-frequency oscillator. Instances 1 and 2 monitor the two high-frequency oscillators. Software controls all three through one 12-bit control word. Each instance owns a 4-bit slice of that word, holding a 2-bit length select, a self-clearing restart bit and an enable bit. The oscillator tick is an enable pulse that has already been brought into the system clock domain.

Top module: `osc_start_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control word, all expiry pulses and all reached levels return to zero.
- R2: Instance i owns control bits [4i+3:4i]: length select at [4i+1:4i], restart at [4i+2], enable at [4i+3]. Instance 0 is the low-frequency one. `ctrl_rdata` returns the stored select and enable bits and reads every restart bit as 0.
- R3: For the low-frequency instance, select codes 0, 1, 2 and 3 give terminal counts of 4096, 8192, 16384 and 32768 accepted ticks.
- R4: For the high-frequency instances, select codes 0, 1, 2 and 3 give terminal counts of 2048, 4096, 8192 and 16384 accepted ticks.
- R5: A tick is accepted only on a clock edge where both `osc_tick[i]` and `osc_run[i]` are 1. Other edges leave the count unchanged.
- R6: While an instance's enable bit is 0, its counter, reached level and pulse are held at zero. Enabling it again requires a full terminal count.
- R7: A control write with restart bit 1 clears that instance's count and reached level at the same edge, before that edge's tick is counted. The write leaves other instances untouched.
- R8: The edge that accepts the terminal tick drives `expire[i]` high for exactly one cycle and sets `reached[i]`. The counter then stops without wrapping, and no further pulse comes until a restart or a disable.
- R9: A select change takes effect against the current count. If the new terminal count is already passed, expiry fires on the next accepted tick.
- R10: The instances count and expire independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 12 | Control word written when `ctrl_wr` is 1 |
| ctrl_rdata | output | 12 | Stored control word, restart bits read as 0 |
| osc_tick | input | 3 | One-cycle oscillator tick per instance, in the system clock domain |
| osc_run | input | 3 | Oscillator-running indication per instance |
| expire | output | 3 | One-cycle start-up counter expiry pulse per instance |
| reached | output | 3 | Level: terminal count reached since last clear |

## Verification
The assertions take for granted that `osc_tick`, `osc_run` and the control write port are synchronous signals that are stable around each rising edge. They also take for granted that a write is a single-cycle strobe. Under those assumptions, a pulse can be tied to an accepted tick on the edge before it, and a disable or restart can be tied to the clear that follows. The stimulus changes every input only at the falling edge. It issues each control write as a one-cycle strobe. It shapes the tick and run patterns cycle by cycle, so that the accepted-tick count at each edge is known exactly.

// File: rtl/osc_mon_pkg.sv
// Shared constants and helpers for the oscillator startup fault counter.
// Assumes every instance has a 4-bit control slice with a fixed field order.
package osc_mon_pkg;
    localparam int FIELD_W     = 4;  // control bits owned by one instance
    localparam int SEL_LSB     = 0;  // 2-bit length select
    localparam int SEL_W       = 2;
    localparam int RESTART_BIT = 2;  // write-one restart, reads zero
    localparam int EN_BIT      = 3;  // counter enable

    // Picks the log2 of the shortest terminal count for instance idx.
    function automatic int base_log2(input int idx, input int num_lf,
                                     input int lf_log2, input int hf_log2);
        return (idx < num_lf) ? lf_log2 : hf_log2;
    endfunction
endpackage

// File: rtl/osc_ctrl_regs.sv
// Control word storage for all monitored oscillators.
// Holds the select and enable fields for each instance. It turns the restart
// bit of a write into a one-cycle strobe that is never stored, so that bit
// always reads back as zero. Assumes ctrl_wr is a one-cycle strobe in the clk domain.
module osc_ctrl_regs
    import osc_mon_pkg::*;
#(
    parameter int NUM_OSC = 3,
    localparam int DW     = FIELD_W * NUM_OSC
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [DW-1:0]                 wdata,
    output logic [NUM_OSC-1:0][SEL_W-1:0] sel,
    output logic [NUM_OSC-1:0]            en,
    output logic [NUM_OSC-1:0]            restart,
    output logic [DW-1:0]                 rdata
);
    logic [NUM_OSC-1:0][SEL_W-1:0] sel_q;
    logic [NUM_OSC-1:0]            en_q;

    for (genvar i = 0; i < NUM_OSC; i++) begin : g_slice
        localparam int B = FIELD_W * i;

        // Captures the select and enable fields of slice i on a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[i] <= '0;
                en_q[i]  <= 1'b0;
            end else if (wr) begin
                sel_q[i] <= wdata[B+SEL_LSB +: SEL_W];
                en_q[i]  <= wdata[B+EN_BIT];
            end
        end

        // Decodes the restart strobe and builds the read-back slice.
        always_comb begin
            restart[i]                   = wr & wdata[B+RESTART_BIT];
            rdata[B+SEL_LSB +: SEL_W]    = sel_q[i];
            rdata[B+RESTART_BIT]         = 1'b0;
            rdata[B+EN_BIT]              = en_q[i];
        end
    end

    assign sel = sel_q;
    assign en  = en_q;
endmodule

// File: rtl/osc_start_counter.sv
// Start-up counter for one oscillator.
// Counts edges where tick and run are both high, up to a terminal count of
// 2**(BASE_LOG2+sel). On the edge that reaches or passes the terminal count, it
// pulses expire for one cycle, latches reached and stops. Disable or restart
// clears the state. Assumes CW is wide enough for 2**(BASE_LOG2+3).
module osc_start_counter #(
    parameter int BASE_LOG2 = 11,
    parameter int CW        = BASE_LOG2 + 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       restart,
    input  logic [1:0] sel,
    input  logic       tick,
    input  logic       run,
    output logic       expire,
    output logic       reached
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] term;
    logic          accept;
    logic          hit;

    // Computes the terminal count and whether this edge's tick completes the count.
    always_comb begin
        term    = CW'(1) << (BASE_LOG2 + int'(sel));
        cnt_inc = cnt + CW'(1);
        accept  = tick & run & ~reached;
        hit     = accept & (cnt_inc >= term);
    end

    // Advances the count, latches the reached level and forms the one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            reached <= 1'b0;
            expire  <= 1'b0;
        end else if (!en || restart) begin
            cnt     <= '0;
            reached <= 1'b0;
            expire  <= 1'b0;
        end else begin
            expire <= hit;
            if (accept) cnt <= cnt_inc;
            if (hit) reached <= 1'b1;
        end
    end
endmodule

// File: rtl/osc_start_monitor.sv
// Top of the oscillator startup fault counter.
// Holds one control register and NUM_OSC counters. The first NUM_LF counters
// use the low-frequency length table, and the rest use the high-frequency
// table. Assumes osc_tick and osc_run are already synchronous to clk.
module osc_start_monitor
    import osc_mon_pkg::*;
#(
    parameter int NUM_OSC = 3,
    parameter int NUM_LF  = 1,
    parameter int LF_LOG2 = 12,
    parameter int HF_LOG2 = 11,
    localparam int DW     = FIELD_W * NUM_OSC,
    localparam int CW     = ((LF_LOG2 > HF_LOG2) ? LF_LOG2 : HF_LOG2) + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic [DW-1:0]      ctrl_wdata,
    output logic [DW-1:0]      ctrl_rdata,
    input  logic [NUM_OSC-1:0] osc_tick,
    input  logic [NUM_OSC-1:0] osc_run,
    output logic [NUM_OSC-1:0] expire,
    output logic [NUM_OSC-1:0] reached
);
    logic [NUM_OSC-1:0][SEL_W-1:0] sel;
    logic [NUM_OSC-1:0]            en;
    logic [NUM_OSC-1:0]            restart;

    osc_ctrl_regs #(.NUM_OSC(NUM_OSC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctrl_wr),
        .wdata   (ctrl_wdata),
        .sel     (sel),
        .en      (en),
        .restart (restart),
        .rdata   (ctrl_rdata)
    );

    for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
        localparam int BL = base_log2(i, NUM_LF, LF_LOG2, HF_LOG2);

        osc_start_counter #(.BASE_LOG2(BL), .CW(CW)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en[i]),
            .restart (restart[i]),
            .sel     (sel[i]),
            .tick    (osc_tick[i]),
            .run     (osc_run[i]),
            .expire  (expire[i]),
            .reached (reached[i])
        );
    end
endmodule

// File: rtl/osc_start_monitor_chk.sv
// Property checker for osc_start_monitor, attached with bind.
// Assumes inputs are synchronous and ctrl_wr is a one-cycle strobe.
module osc_start_monitor_chk
    import osc_mon_pkg::*;
#(
    parameter int NUM_OSC = 3,
    localparam int DW     = FIELD_W * NUM_OSC
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctrl_wr,
    input logic [DW-1:0]      ctrl_wdata,
    input logic [DW-1:0]      ctrl_rdata,
    input logic [NUM_OSC-1:0] osc_tick,
    input logic [NUM_OSC-1:0] osc_run,
    input logic [NUM_OSC-1:0] expire,
    input logic [NUM_OSC-1:0] reached
);
    // R1: reset clears the control word and outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ctrl_rdata == '0 && expire == '0 && reached == '0));

    for (genvar i = 0; i < NUM_OSC; i++) begin : g_chk
        localparam int B = FIELD_W * i;

        // R5: a pulse always follows an accepted tick
        a_r5_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] |-> $past(osc_tick[i] && osc_run[i]));

        // R6: disabled counter stays cleared
        a_r6_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(ctrl_rdata[B+EN_BIT]) |-> (!reached[i] && !expire[i]));

        // R7: restart write clears the state on the next cycle
        a_r7_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && ctrl_wdata[B+RESTART_BIT]) |=> (!reached[i] && !expire[i]));

        // R8: pulse lasts one cycle
        a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] |=> !expire[i]);

        // R8: pulse coincides with reached rising
        a_r8_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] |-> (reached[i] && !$past(reached[i])));

        // R8: reached holds until disable or restart
        a_r8_reached_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (reached[i] && ctrl_rdata[B+EN_BIT] && !(ctrl_wr && ctrl_wdata[B+RESTART_BIT]))
            |=> reached[i]);
    end
endmodule

bind osc_start_monitor osc_start_monitor_chk #(.NUM_OSC(NUM_OSC)) u_chk (.*);

// File: tb/tb_osc_start_monitor.sv
`timescale 1ns/1ps
module tb_osc_start_monitor;
    localparam int N = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr = 1'b0;
    logic [11:0]   ctrl_wdata = '0;
    logic [11:0]   ctrl_rdata;
    logic [N-1:0]  osc_tick = '0;
    logic [N-1:0]  osc_run = '0;
    logic [N-1:0]  expire;
    logic [N-1:0]  reached;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    osc_start_monitor dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .osc_tick(osc_tick), .osc_run(osc_run),
        .expire(expire), .reached(reached)
    );

    // Builds one 4-bit control slice: enable, restart, select.
    function automatic logic [3:0] slice(input bit en, input bit rs, input logic [1:0] sel);
        return {en, rs, sel};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issues a one-cycle write; called and returns at a falling edge.
    task automatic wr_ctrl(input logic [11:0] w);
        ctrl_wr = 1'b1;
        ctrl_wdata = w;
        @(posedge clk);
        @(negedge clk);
        ctrl_wr = 1'b0;
        ctrl_wdata = '0;
    endtask

    // Runs limit edges and records the edge of each first pulse and the pulse count.
    task automatic measure(input int limit, input int e0, input int e1, input int e2,
                           input string req);
        int first[N];
        int npulse[N];
        int exp_n[N];
        exp_n[0] = e0; exp_n[1] = e1; exp_n[2] = e2;
        for (int k = 0; k < N; k++) begin first[k] = 0; npulse[k] = 0; end
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            for (int k = 0; k < N; k++) begin
                if (expire[k]) begin
                    npulse[k]++;
                    if (first[k] == 0) first[k] = n;
                end
            end
        end
        for (int k = 0; k < N; k++) begin
            if (exp_n[k] > 0) begin
                check(first[k] == exp_n[k], req, first[k], exp_n[k]);
                check(npulse[k] == 1, "R8 single pulse", npulse[k], 1);
                check(reached[k] == 1'b1, "R8 reached held", int'(reached[k]), 1);
            end
        end
    endtask

    task automatic t_reset;
        check(ctrl_rdata == 12'h000, "R1 control word", int'(ctrl_rdata), 0);
        check(expire == '0, "R1 expire", int'(expire), 0);
        check(reached == '0, "R1 reached", int'(reached), 0);
    endtask

    task automatic t_readback;
        wr_ctrl(12'hFFF);
        check(ctrl_rdata == 12'hBBB, "R2 R7 readback restart zero", int'(ctrl_rdata), 12'hBBB);
        wr_ctrl(12'h000);
        check(ctrl_rdata == 12'h000, "R2 readback cleared", int'(ctrl_rdata), 0);
    endtask

    // R3 R4 R10: three instances counting different lengths in parallel.
    task automatic t_lengths(input logic [1:0] s0, input logic [1:0] s1, input logic [1:0] s2);
        int e0, e1, e2, mx;
        e0 = 4096 << s0; e1 = 2048 << s1; e2 = 2048 << s2;
        mx = (e0 > e1) ? e0 : e1;
        mx = (mx > e2) ? mx : e2;
        osc_tick = '1; osc_run = '1;
        wr_ctrl({slice(1, 1, s2), slice(1, 1, s1), slice(1, 1, s0)});
        measure(mx + 20, e0, e1, e2, "R3 R4 R10 terminal count");
        wr_ctrl(12'h000);
    endtask

    // R5: run gating on instance 1, alternating ticks on instance 2.
    task automatic t_gating;
        int first1 = 0;
        int first2 = 0;
        osc_tick = '1; osc_run = '1;
        wr_ctrl({slice(1, 1, 2'd0), slice(1, 1, 2'd0), slice(0, 0, 2'd0)});
        for (int n = 1; n <= 4200; n++) begin
            osc_run[1]  = (n > 1000);
            osc_tick[2] = n[0];
            @(negedge clk);
            if (expire[1] && first1 == 0) first1 = n;
            if (expire[2] && first2 == 0) first2 = n;
        end
        check(first1 == 3048, "R5 run gating", first1, 3048);
        check(first2 == 4095, "R5 tick gating", first2, 4095);
        osc_tick = '1; osc_run = '1;
        wr_ctrl(12'h000);
    endtask

    // R6: disable clears, re-enable needs a full count.
    task automatic t_disable;
        int seen = 0;
        osc_tick = '1; osc_run = '1;
        wr_ctrl({4'h0, slice(1, 1, 2'd0), 4'h0});
        repeat (1000) @(negedge clk);
        wr_ctrl(12'h000);
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (expire[1] || reached[1]) seen++;
        end
        check(seen == 0, "R6 disabled held clear", seen, 0);
        wr_ctrl({4'h0, slice(1, 0, 2'd0), 4'h0});
        measure(2100, 0, 2048, 0, "R6 full count after enable");
        wr_ctrl(12'h000);
    endtask

    // R7 R10: restart one instance while another keeps counting.
    task automatic t_restart;
        osc_tick = '1; osc_run = '1;
        wr_ctrl({4'h0, slice(1, 1, 2'd0), slice(1, 1, 2'd0)});
        repeat (1500) @(negedge clk);
        wr_ctrl({4'h0, slice(1, 1, 2'd0), slice(1, 0, 2'd0)});
        measure(2700, 2595, 2048, 0, "R7 R10 restart");
        wr_ctrl(12'h000);
    endtask

    // R9: select lowered below the count, and select raised mid-count.
    task automatic t_sel_change;
        osc_tick = '1; osc_run = '1;
        wr_ctrl({4'h0, slice(1, 1, 2'd3), 4'h0});
        repeat (5000) @(negedge clk);
        check(reached[1] == 1'b0, "R9 not yet reached", int'(reached[1]), 0);
        wr_ctrl({4'h0, slice(1, 0, 2'd0), 4'h0});
        measure(40, 0, 1, 0, "R9 lowered select fires next tick");
        wr_ctrl(12'h000);
        wr_ctrl({4'h0, slice(1, 1, 2'd0), 4'h0});
        repeat (1000) @(negedge clk);
        wr_ctrl({4'h0, slice(1, 0, 2'd1), 4'h0});
        measure(3200, 0, 3095, 0, "R9 raised select keeps count");
        wr_ctrl(12'h000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_readback();
        t_lengths(2'd0, 2'd0, 2'd1);
        t_lengths(2'd3, 2'd3, 2'd2);
        t_lengths(2'd2, 2'd2, 2'd0);
        t_lengths(2'd1, 2'd1, 2'd3);
        t_gating();
        t_disable();
        t_restart();
        t_sel_change();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule